// File: doc/BRIEF.md
# Performance Monitor Event Selector Bank

This block holds the event-selector registers of an I/O memory management unit's hardware performance monitor. Each selector is a 64-bit register that software reaches through a memory-mapped write port (offset, 64-bit data, strobe) and a matching combinational read port. The selectors sit at an 8-byte stride starting from a configurable base offset. The lowest 15 bits of each selector hold the event ID. The downstream counter logic decodes that field, and the block drives every selector's current event ID onto a flat output bus.

Every write that lands on an implemented selector is legalized before it is stored. If the written event ID does not exceed the configured largest legal ID, the block stores the whole word. If the event ID is too large, the block keeps the previously stored event ID and stores only the remaining upper bits. The block drops writes to selectors of unimplemented counters, to offsets that are not 8-byte aligned, and to offsets outside the selector window. When the performance-monitor capability is absent, every selector reads as zero and ignores writes. A nonzero event-ID limit in that case is an illegal configuration, and the block flags it.

Top module: `evsel_bank`

## Requirements
- R1: After reset every selector holds zero: reads of every selector return zero and the event-ID bus is all zero.
- R2: A write to an implemented selector whose bits [14:0] are less than or equal to the limit stores all 64 written bits, and those bits [14:0] appear on that selector's 15-bit slice of the event-ID bus (selector k at bits [15k+14:15k]).
- R3: A write whose bits [14:0] exceed the limit leaves the stored bits [14:0] at their previous value and stores written bits [63:15].
- R4: The selector addressed is (offset - base) / 8, and selector k sits at base + 8k. A write changes only the selector it addresses.
- R5: Writes to a selector index at or above NUM_CTR - 1 are discarded, and reads of such an index return zero.
- R6: Writes to offsets that are not 8-byte aligned, that lie below the base, or that lie beyond the NUM_SLOT-entry window change nothing, and reads there return zero.
- R7: With the capability disabled, every selector reads as zero, the event-ID bus stays zero, and writes have no effect.
- R8: The configuration-error output is 1 exactly when the capability is disabled and the event-ID limit is nonzero.
- R9: A write becomes visible on the clock edge that samples the strobe; a read of the same selector in that cycle returns the old value.
- R10: An event ID equal to the limit is accepted and one above it is rejected, so a stored event ID never exceeds the limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_ofs | input | 12 | Byte offset of the write |
| wr_data | input | 64 | Write data |
| rd_ofs | input | 12 | Byte offset of the read |
| rd_data | output | 64 | Read data of the addressed selector, zero if none |
| evt_id_o | output | 15*(NUM_CTR-1) | Current event ID of every implemented selector |
| cfg_err | output | 1 | Illegal configuration flag |

## Verification
The bench targets the limit boundary, an ID equal to the limit and one above it. A design that compares with the wrong sense, or masks instead of holding, would store a trimmed or illegal ID. Rejected writes must still update the upper bits; a design that drops the whole write would lose them. The bench writes the first index past the implemented selectors, the far end of the window, a misaligned offset and offsets below the base. An off-by-one in the implemented-count bound or a decoder that ignores the low bits would corrupt a neighbour. A same-cycle read around a write catches a write-through path. A second and third instance with the capability off check that reads stay zero and that the configuration flag tracks the limit.

// File: rtl/evsel_pkg.sv
package evsel_pkg;
  localparam int OFS_W     = 12;
  localparam int EVT_W     = 15;
  localparam int REG_W     = 64;
  localparam int STRIDE_LG = 3;
  localparam int SLOT_W    = OFS_W - STRIDE_LG;

  typedef logic [REG_W-1:0]  sel_word_t;
  typedef logic [EVT_W-1:0]  evt_id_t;
  typedef logic [OFS_W-1:0]  ofs_t;
  typedef logic [SLOT_W-1:0] slot_t;

  // Selector number addressed by an offset, relative to the window base.
  function automatic slot_t slot_of(ofs_t ofs, ofs_t base);
    ofs_t diff;
    diff = ofs - base;
    return diff[OFS_W-1:STRIDE_LG];
  endfunction

  function automatic logic is_aligned(ofs_t ofs);
    return ofs[STRIDE_LG-1:0] == '0;
  endfunction

  // True when the offset names one of the nslot selector slots.
  function automatic logic slot_in_window(ofs_t ofs, ofs_t base, int nslot);
    return is_aligned(ofs) && (ofs >= base) && (int'(slot_of(ofs, base)) < nslot);
  endfunction

  function automatic logic id_too_big(evt_id_t id, evt_id_t lim);
    return id > lim;
  endfunction

  // Legal value to store: an over-limit ID keeps the old ID, upper bits always land.
  function automatic sel_word_t legalize(sel_word_t wr, sel_word_t old, evt_id_t lim);
    sel_word_t res;
    res = wr;
    if (id_too_big(wr[EVT_W-1:0], lim)) res[EVT_W-1:0] = old[EVT_W-1:0];
    return res;
  endfunction

  function automatic logic cfg_illegal(logic hpm_on, evt_id_t lim);
    return !hpm_on && (lim != '0);
  endfunction
endpackage

// File: rtl/evsel_addr_dec.sv
module evsel_addr_dec
  import evsel_pkg::*;
#(
  parameter ofs_t BASE_OFS = 12'h208,
  parameter int   NUM_SLOT = 31,
  parameter int   NSEL     = 7,
  parameter bit   HPM_EN   = 1'b1
) (
  input  logic            en,
  input  ofs_t            ofs,
  output logic [NSEL-1:0] sel,
  output logic            hit
);
  slot_t slot;
  logic  in_win;

  always_comb begin
    slot   = slot_of(ofs, BASE_OFS);
    in_win = slot_in_window(ofs, BASE_OFS, NUM_SLOT);
  end

  for (genvar k = 0; k < NSEL; k++) begin : g_sel
    assign sel[k] = en && HPM_EN && in_win && (slot == SLOT_W'(k));
  end

  assign hit = |sel;
endmodule

// File: rtl/evsel_legalizer.sv
module evsel_legalizer
  import evsel_pkg::*;
#(
  parameter evt_id_t EVT_LIMIT = 15'd100
) (
  input  sel_word_t wr_word,
  input  sel_word_t old_word,
  output sel_word_t new_word,
  output logic      reject
);
  always_comb begin
    new_word = legalize(wr_word, old_word, EVT_LIMIT);
    reject   = id_too_big(wr_word[EVT_W-1:0], EVT_LIMIT);
  end
endmodule

// File: rtl/evsel_slot.sv
module evsel_slot
  import evsel_pkg::*;
#(
  parameter evt_id_t EVT_LIMIT = 15'd100
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      we,
  input  sel_word_t wr_word,
  output sel_word_t q,
  output logic      rejected
);
  sel_word_t nxt;
  logic      rej;

  evsel_legalizer #(.EVT_LIMIT(EVT_LIMIT)) u_legal (
    .wr_word (wr_word),
    .old_word(q),
    .new_word(nxt),
    .reject  (rej)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= nxt;
  end

  assign rejected = we && rej;
endmodule

// File: rtl/evsel_bank.sv
module evsel_bank
  import evsel_pkg::*;
#(
  parameter ofs_t    BASE_OFS  = 12'h208,
  parameter int      NUM_CTR   = 8,
  parameter int      NUM_SLOT  = 31,
  parameter evt_id_t EVT_LIMIT = 15'd100,
  parameter bit      HPM_EN    = 1'b1,
  localparam int     NSEL      = NUM_CTR - 1,
  localparam int     EVT_BUS_W = NSEL * EVT_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [OFS_W-1:0]     wr_ofs,
  input  logic [REG_W-1:0]     wr_data,
  input  logic [OFS_W-1:0]     rd_ofs,
  output logic [REG_W-1:0]     rd_data,
  output logic [EVT_BUS_W-1:0] evt_id_o,
  output logic                 cfg_err
);
  logic [NSEL-1:0] wr_sel;
  logic [NSEL-1:0] rd_sel;
  logic [NSEL-1:0] rej_vec;
  logic            wr_hit;
  logic            rd_hit;
  logic            wr_reject;
  sel_word_t       q_arr [NSEL];
  sel_word_t       rd_mux;

  evsel_addr_dec #(
    .BASE_OFS(BASE_OFS), .NUM_SLOT(NUM_SLOT), .NSEL(NSEL), .HPM_EN(HPM_EN)
  ) u_wr_dec (
    .en (wr_en),
    .ofs(wr_ofs),
    .sel(wr_sel),
    .hit(wr_hit)
  );

  evsel_addr_dec #(
    .BASE_OFS(BASE_OFS), .NUM_SLOT(NUM_SLOT), .NSEL(NSEL), .HPM_EN(HPM_EN)
  ) u_rd_dec (
    .en (1'b1),
    .ofs(rd_ofs),
    .sel(rd_sel),
    .hit(rd_hit)
  );

  for (genvar k = 0; k < NSEL; k++) begin : g_slot
    evsel_slot #(.EVT_LIMIT(EVT_LIMIT)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (wr_sel[k]),
      .wr_word (wr_data),
      .q       (q_arr[k]),
      .rejected(rej_vec[k])
    );
    assign evt_id_o[k*EVT_W +: EVT_W] = q_arr[k][EVT_W-1:0];
  end

  always_comb begin
    rd_mux = '0;
    for (int k = 0; k < NSEL; k++) begin
      if (rd_sel[k]) rd_mux = rd_mux | q_arr[k];
    end
  end

  assign rd_data   = rd_hit ? rd_mux : '0;
  assign wr_reject = |rej_vec;
  assign cfg_err   = cfg_illegal(HPM_EN, EVT_LIMIT);
endmodule

// File: rtl/evsel_bank_chk.sv
module evsel_bank_chk
  import evsel_pkg::*;
#(
  parameter ofs_t    BASE_OFS  = 12'h208,
  parameter int      NUM_CTR   = 8,
  parameter evt_id_t EVT_LIMIT = 15'd100,
  parameter bit      HPM_EN    = 1'b1,
  localparam int     NSEL      = NUM_CTR - 1,
  localparam int     EVT_BUS_W = NSEL * EVT_W
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en,
  input logic [OFS_W-1:0]     wr_ofs,
  input logic [REG_W-1:0]     wr_data,
  input logic [OFS_W-1:0]     rd_ofs,
  input logic [REG_W-1:0]     rd_data,
  input logic [EVT_BUS_W-1:0] evt_id_o,
  input logic                 wr_hit,
  input logic                 wr_reject
);
  logic [NSEL-1:0] tgt;
  logic            wr_legal_slot;
  logic            rd_legal_slot;

  assign wr_legal_slot = HPM_EN && (wr_ofs[2:0] == 3'd0) && (wr_ofs >= BASE_OFS)
                         && (((wr_ofs - BASE_OFS) >> 3) < OFS_W'(NSEL));
  assign rd_legal_slot = HPM_EN && (rd_ofs[2:0] == 3'd0) && (rd_ofs >= BASE_OFS)
                         && (((rd_ofs - BASE_OFS) >> 3) < OFS_W'(NSEL));

  for (genvar g = 0; g < NSEL; g++) begin : g_chk
    assign tgt[g] = wr_en && wr_legal_slot && (((wr_ofs - BASE_OFS) >> 3) == OFS_W'(g));

    AST_ACCEPT_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt[g] && wr_data[EVT_W-1:0] <= EVT_LIMIT) |=> evt_id_o[g*EVT_W +: EVT_W] == $past(wr_data[EVT_W-1:0])); // R2
    AST_REJECT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt[g] && wr_data[EVT_W-1:0] > EVT_LIMIT) |=> $stable(evt_id_o[g*EVT_W +: EVT_W])); // R3
    AST_OTHERS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !tgt[g] |=> $stable(evt_id_o[g*EVT_W +: EVT_W])); // R4
    AST_ID_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      evt_id_o[g*EVT_W +: EVT_W] <= EVT_LIMIT); // R10
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> evt_id_o == '0); // R1
  AST_HIT_ONLY_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |-> (wr_en && wr_legal_slot)); // R5
  AST_REJECT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reject |-> (wr_hit && wr_data[EVT_W-1:0] > EVT_LIMIT)); // R3
  AST_RD_ZERO_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_legal_slot |-> rd_data == '0); // R6
  AST_TGT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tgt)); // R4
endmodule

bind evsel_bank evsel_bank_chk #(
  .BASE_OFS(BASE_OFS), .NUM_CTR(NUM_CTR), .EVT_LIMIT(EVT_LIMIT), .HPM_EN(HPM_EN)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_ofs   (wr_ofs),
  .wr_data  (wr_data),
  .rd_ofs   (rd_ofs),
  .rd_data  (rd_data),
  .evt_id_o (evt_id_o),
  .wr_hit   (wr_hit),
  .wr_reject(wr_reject)
);

// File: tb/evsel_bank_test.sv
module evsel_bank_test;
  localparam logic [11:0] BASE = 12'h208;
  localparam int          NCTR = 8;
  localparam int          NS   = NCTR - 1;
  localparam logic [14:0] LIM  = 15'd100;
  localparam logic [63:0] IDM  = 64'h7FFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [11:0] wr_ofs = '0;
  logic [63:0] wr_data = '0;
  logic [11:0] rd_ofs = '0;
  logic [63:0] rd_data, rd_off, rd_off0;
  logic [NS*15-1:0] evt, evt_off, evt_off0;
  logic        err_on, err_off, err_off0;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [63:0] shadow [NS];

  always #4 clk = ~clk;

  evsel_bank #(.BASE_OFS(BASE), .NUM_CTR(NCTR), .NUM_SLOT(31), .EVT_LIMIT(LIM), .HPM_EN(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ofs(wr_ofs), .wr_data(wr_data),
    .rd_ofs(rd_ofs), .rd_data(rd_data), .evt_id_o(evt), .cfg_err(err_on));
  evsel_bank #(.BASE_OFS(BASE), .NUM_CTR(NCTR), .NUM_SLOT(31), .EVT_LIMIT(15'd5), .HPM_EN(1'b0)) uut_off (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ofs(wr_ofs), .wr_data(wr_data),
    .rd_ofs(rd_ofs), .rd_data(rd_off), .evt_id_o(evt_off), .cfg_err(err_off));
  evsel_bank #(.BASE_OFS(BASE), .NUM_CTR(NCTR), .NUM_SLOT(31), .EVT_LIMIT(15'd0), .HPM_EN(1'b0)) uut_off0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ofs(wr_ofs), .wr_data(wr_data),
    .rd_ofs(rd_ofs), .rd_data(rd_off0), .evt_id_o(evt_off0), .cfg_err(err_off0));

  function automatic logic [63:0] expect_word(logic [63:0] wr, logic [63:0] old);
    if ((wr & IDM) > 64'(LIM)) return (wr & ~IDM) | (old & IDM);
    return wr;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_sel(logic [11:0] ofs, logic [63:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_ofs = ofs; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic read_chk(string req, logic [11:0] ofs, logic [63:0] exp);
    rd_ofs = ofs;
    #1;
    check(req, rd_data, exp);
  endtask

  task automatic check_all(string req);
    for (int k = 0; k < NS; k++) begin
      read_chk(req, BASE + 12'(8*k), shadow[k]);
      check(req, 64'(evt[k*15 +: 15]), shadow[k] & IDM);
    end
  endtask

  task automatic t_reset;   // R1
    for (int k = 0; k < NS; k++) shadow[k] = '0;
    check_all("R1");
    check("R1", 64'(evt == '0), 64'd1);
  endtask

  task automatic t_accept;  // R2
    write_sel(BASE + 12'd16, 64'hDEAD_BEEF_0000_0042);
    shadow[2] = 64'hDEAD_BEEF_0000_0042;
    read_chk("R2", BASE + 12'd16, shadow[2]);
    check("R2", 64'(evt[2*15 +: 15]), 64'h42);
    check_all("R2");
  endtask

  task automatic t_reject;  // R3
    logic [63:0] d;
    d = 64'h1234_5678_9ABC_FFFF;
    write_sel(BASE + 12'd16, d);
    shadow[2] = expect_word(d, shadow[2]);
    check("R3", shadow[2], 64'h1234_5678_9ABC_8042);
    read_chk("R3", BASE + 12'd16, shadow[2]);
    check("R3", 64'(evt[2*15 +: 15]), 64'h42);
  endtask

  task automatic t_boundary; // R10
    write_sel(BASE, 64'(LIM));
    shadow[0] = 64'(LIM);
    read_chk("R10", BASE, 64'(LIM));
    write_sel(BASE, 64'hAAAA_0000_0000_0000 | 64'(LIM + 15'd1));
    shadow[0] = 64'hAAAA_0000_0000_0000 | 64'(LIM);
    read_chk("R10", BASE, shadow[0]);
    check("R10", 64'(evt[0 +: 15]), 64'(LIM));
  endtask

  task automatic t_stride;  // R4
    for (int k = 0; k < NS; k++) begin
      logic [63:0] d;
      d = {32'(k + 1), 32'(k + 10)};
      write_sel(BASE + 12'(8*k), d);
      shadow[k] = expect_word(d, shadow[k]);
    end
    check_all("R4");
  endtask

  task automatic t_unimpl;  // R5
    write_sel(BASE + 12'(8*NS), 64'h0000_0000_0000_0007);
    write_sel(BASE + 12'(8*30), 64'hFFFF_0000_0000_0003);
    read_chk("R5", BASE + 12'(8*NS), 64'd0);
    read_chk("R5", BASE + 12'(8*30), 64'd0);
    check_all("R5");
  endtask

  task automatic t_window;  // R6
    write_sel(BASE + 12'd4, 64'h5555_0000_0000_0001);
    write_sel(BASE + 12'd1, 64'h5555_0000_0000_0002);
    write_sel(BASE - 12'd8, 64'h5555_0000_0000_0003);
    write_sel(BASE + 12'(8*31), 64'h5555_0000_0000_0004);
    read_chk("R6", BASE + 12'd4, 64'd0);
    read_chk("R6", BASE - 12'd8, 64'd0);
    check_all("R6");
  endtask

  task automatic t_same_cycle; // R9
    logic [63:0] old, d;
    old = shadow[3];
    d   = 64'h0F0F_0000_0000_0021;
    @(negedge clk);
    wr_en = 1'b1; wr_ofs = BASE + 12'd24; wr_data = d; rd_ofs = BASE + 12'd24;
    #1;
    check("R9", rd_data, old);
    @(negedge clk);
    wr_en = 1'b0;
    shadow[3] = expect_word(d, old);
    #1;
    check("R9", rd_data, shadow[3]);
  endtask

  task automatic t_no_hpm;  // R7 R8
    for (int k = 0; k < NS; k++) begin
      rd_ofs = BASE + 12'(8*k);
      #1;
      check("R7", rd_off, 64'd0);
      check("R7", rd_off0, 64'd0);
    end
    check("R7", 64'(evt_off == '0), 64'd1);
    check("R8", 64'(err_off), 64'd1);
    check("R8", 64'(err_off0), 64'd0);
    check("R8", 64'(err_on), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_accept();
    t_reject();
    t_boundary();
    t_stride();
    t_unimpl();
    t_window();
    t_same_cycle();
    t_no_hpm();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule